// File: doc/BRIEF.md
# External Interrupt Edge Detector

This unit turns port pin activity into interrupt requests for a small microcontroller. It serves a fixed number of interrupt vectors. Each vector owns a group of port pins, chosen by a per-vector pin mask parameter. Inside a group, each pin whose interrupt enable is set takes part in a wired-AND merge. A pin that is disabled, or that lies outside the group, counts as a constant high.

The merged line of each vector goes to an event detector. This detector compares the line with its own value from the previous clock and applies the vector's two-bit sensitivity code. A qualifying event sets a pending latch, and the latch drives that vector's request output. The CPU clears the latch by fetching the vector, which pulses the acknowledge bit for that vector. Writing a new sensitivity code also clears the latch, which lets software discard an unwanted request.

Because a disabled pin reads as high, enabling or disabling a pin that is held low produces a real edge on the merged line. CPU masking and priority between vectors are not part of this unit.

Top module: `ext_irq_unit`

## Requirements
- R1: The merged line of vector v is the AND, over the pins in that vector's group mask, of (pin level OR NOT pin enable). Pins outside the mask have no effect. While one enabled pin of the group is low, edges on the other pins of the group produce no request.
- R2: Sensitivity code 2'b01 (rising only): a low-to-high change of the merged line sets the request. The request is visible on `irq_req` after the clock edge at which the new level is sampled. A high-to-low change sets nothing.
- R3: Sensitivity code 2'b10 (falling only): a high-to-low change of the merged line sets the request. A rising change sets nothing and leaves an existing request unchanged.
- R4: Sensitivity code 2'b11 (both edges): either direction of change sets the request.
- R5: Sensitivity code 2'b00 (falling edge or low level): the request is set on every clock while the merged line is low, so it comes back at once after an acknowledge while the line stays low.
- R6: An acknowledge bit high for one clock clears that vector's pending request, provided no event and no sensitivity change occurs in the same cycle.
- R7: An event that coincides with an acknowledge on the same vector leaves the request set.
- R8: A sensitivity code that differs from the code of the previous clock clears the vector's request. This clear takes priority over an event in the same cycle.
- R9: Setting or clearing the enable of a pin that is held low produces an edge on the merged line. This edge sets a request whenever the sensitivity code includes that direction.
- R10: While `rst_n` is low, every request output is 0. The sensitivity field of vector v occupies `sens_cfg[2v+1:2v]`.
- R11: Vectors are independent. An acknowledge or an event on one vector does not change the request of another vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | PIN_W | Synchronized pin levels |
| pin_ien | input | PIN_W | Per-pin interrupt enable from the port option bits |
| sens_cfg | input | 2*NUM_VEC | Two-bit sensitivity code per vector |
| ack | input | NUM_VEC | Vector-fetch acknowledge, one bit per vector |
| irq_req | output | NUM_VEC | Pending request per vector |

## Verification
Two functions can fall in the same cycle on one vector: the acknowledge that clears the latch and a new event that sets it. The bench provokes this by driving a falling edge on a pin of a falling-sensitive vector in the same cycle as that vector's acknowledge, and it expects the request to stay high (R7). A second collision, a sensitivity rewrite landing together with a qualifying edge, is driven the same way, and the bench expects the request to be clear (R8). In both cases the scoreboard holds the request value predicted for the clock after the collision.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENS_LOW_FALL = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } sens_e;

  // Event qualification for one vector: current merged level vs previous
  function automatic logic sens_hit(input sens_e s, input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (s)
      SENS_LOW_FALL: sens_hit = ~cur;
      SENS_RISE:     sens_hit = rise;
      SENS_FALL:     sens_hit = fall;
      default:       sens_hit = rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/ext_irq_merge.sv
module ext_irq_merge #(
  parameter int          PIN_W = 8,
  parameter logic [PIN_W-1:0] MASK = '1
) (
  input  logic [PIN_W-1:0] pin_lvl,
  input  logic [PIN_W-1:0] pin_ien,
  output logic             merged
);
  // Disabled or foreign pins read as high so they never pull the line down
  logic [PIN_W-1:0] term;

  always_comb begin
    term   = pin_lvl | ~pin_ien | ~MASK;
    merged = &term;
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       merged,
  input  logic [1:0] sens,
  input  logic       ack,
  output logic       req,
  output logic       hit,
  output logic       chg
);
  logic       merged_q;
  logic [1:0] sens_q;
  logic       pend_q;

  always_comb begin
    hit = sens_hit(sens_e'(sens), merged, merged_q);
    chg = (sens != sens_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      merged_q <= 1'b1;
      sens_q   <= 2'b00;
      pend_q   <= 1'b0;
    end else begin
      merged_q <= merged;
      sens_q   <= sens;
      if (chg)       pend_q <= 1'b0;
      else if (hit)  pend_q <= 1'b1;
      else if (ack)  pend_q <= 1'b0;
    end
  end

  assign req = pend_q;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int NUM_VEC = 4,
  parameter int PIN_W   = 8,
  parameter logic [NUM_VEC*PIN_W-1:0] GROUP_MASKS = 32'hC0_30_0C_03
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_W-1:0]     pin_lvl,
  input  logic [PIN_W-1:0]     pin_ien,
  input  logic [2*NUM_VEC-1:0] sens_cfg,
  input  logic [NUM_VEC-1:0]   ack,
  output logic [NUM_VEC-1:0]   irq_req
);
  localparam int SENS_W = 2;

  // Observation wires for the checker
  logic [NUM_VEC-1:0] vec_merged;
  logic [NUM_VEC-1:0] vec_hit;
  logic [NUM_VEC-1:0] vec_chg;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    ext_irq_merge #(
      .PIN_W (PIN_W),
      .MASK  (GROUP_MASKS[v*PIN_W +: PIN_W])
    ) u_merge (
      .pin_lvl (pin_lvl),
      .pin_ien (pin_ien),
      .merged  (vec_merged[v])
    );

    ext_irq_detect u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .merged (vec_merged[v]),
      .sens   (sens_cfg[v*SENS_W +: SENS_W]),
      .ack    (ack[v]),
      .req    (irq_req[v]),
      .hit    (vec_hit[v]),
      .chg    (vec_chg[v])
    );
  end
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk #(
  parameter int NUM_VEC = 4,
  parameter int PIN_W   = 8,
  parameter logic [NUM_VEC*PIN_W-1:0] GROUP_MASKS = 32'hC0_30_0C_03
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PIN_W-1:0]   pin_lvl,
  input logic [PIN_W-1:0]   pin_ien,
  input logic [NUM_VEC-1:0] ack,
  input logic [NUM_VEC-1:0] irq_req,
  input logic [NUM_VEC-1:0] vec_merged,
  input logic [NUM_VEC-1:0] vec_hit,
  input logic [NUM_VEC-1:0] vec_chg
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    localparam logic [PIN_W-1:0] M = GROUP_MASKS[v*PIN_W +: PIN_W];

    AST_LOW_PIN_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(M & pin_ien & ~pin_lvl)) |-> !vec_merged[v]); // R1
    AST_IDLE_GROUP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(M & pin_ien & ~pin_lvl)) |-> vec_merged[v]); // R1
    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      vec_chg[v] |=> !irq_req[v]); // R8
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_hit[v] && !vec_chg[v]) |=> irq_req[v]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[v] && !vec_hit[v] && !vec_chg[v]) |=> !irq_req[v]); // R6
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack[v] && !vec_hit[v] && !vec_chg[v]) |=> $stable(irq_req[v])); // R11
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (irq_req == '0)); // R10
endmodule

bind ext_irq_unit ext_irq_unit_chk #(
  .NUM_VEC     (NUM_VEC),
  .PIN_W       (PIN_W),
  .GROUP_MASKS (GROUP_MASKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_lvl    (pin_lvl),
  .pin_ien    (pin_ien),
  .ack        (ack),
  .irq_req    (irq_req),
  .vec_merged (vec_merged),
  .vec_hit    (vec_hit),
  .vec_chg    (vec_chg)
);

// File: tb/ext_irq_unit_tb.sv
module ext_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_lvl = 8'hFF;
  logic [7:0] pin_ien = 8'h00;
  logic [7:0] sens_cfg = 8'h55;
  logic [3:0] ack = 4'h0;
  logic [3:0] irq_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ext_irq_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .pin_ien  (pin_ien),
    .sens_cfg (sens_cfg),
    .ack      (ack),
    .irq_req  (irq_req)
  );

  // Driver: apply inputs at the falling edge, let one rising edge pass,
  // then queue the request vector expected after it.
  task automatic step(input logic [7:0] lvl, input logic [7:0] ien,
                      input logic [7:0] sens, input logic [3:0] ak,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    pin_lvl  = lvl;
    pin_ien  = ien;
    sens_cfg = sens;
    ack      = ak;
    @(posedge clk);
    #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare at the falling edge following each queued item
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_req !== e) begin
        errors++;
        $display("FAIL %s irq_req=%b expected=%b", t, irq_req, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(8'hFF, 8'h00, 8'h55, 4'h0, 4'h0, "R10");
    step(8'hFF, 8'h00, 8'h55, 4'h0, 4'h0, "R10");
    @(negedge clk); rst_n = 1'b1;
    step(8'hFF, 8'h00, 8'h55, 4'h0, 4'h0, "R10");
    step(8'hFF, 8'hFF, 8'h55, 4'h0, 4'h0, "R1");
    // R2 rising only on vector 0
    step(8'hFE, 8'hFF, 8'h55, 4'h0, 4'h0, "R2");
    step(8'hFF, 8'hFF, 8'h55, 4'h0, 4'h1, "R2");
    step(8'hFF, 8'hFF, 8'h55, 4'h1, 4'h0, "R6");
    step(8'hFF, 8'hFF, 8'h55, 4'h0, 4'h0, "R6");
    // R1 a low enabled pin masks its neighbour
    step(8'hFD, 8'hFF, 8'h55, 4'h0, 4'h0, "R1");
    step(8'hFC, 8'hFF, 8'h55, 4'h0, 4'h0, "R1");
    step(8'hFD, 8'hFF, 8'h55, 4'h0, 4'h0, "R1");
    step(8'hFF, 8'hFF, 8'h55, 4'h0, 4'h1, "R1");
    step(8'hFF, 8'hFF, 8'h55, 4'h1, 4'h0, "R6");
    // R1 a disabled low pin does not mask
    step(8'hFD, 8'hFD, 8'h55, 4'h0, 4'h0, "R1");
    step(8'hFC, 8'hFD, 8'h55, 4'h0, 4'h0, "R1");
    step(8'hFD, 8'hFD, 8'h55, 4'h0, 4'h1, "R1");
    step(8'hFD, 8'hFD, 8'h55, 4'h1, 4'h0, "R6");
    // R9 enable toggles on a low pin
    step(8'hFD, 8'hFF, 8'h55, 4'h0, 4'h0, "R9");
    step(8'hFD, 8'hFD, 8'h55, 4'h0, 4'h1, "R9");
    step(8'hFD, 8'hFD, 8'h55, 4'h1, 4'h0, "R6");
    step(8'hFF, 8'hFF, 8'h55, 4'h0, 4'h0, "R9");
    // R3 vector 1 falling only
    step(8'hFF, 8'hFF, 8'h59, 4'h0, 4'h0, "R8");
    step(8'hFB, 8'hFF, 8'h59, 4'h0, 4'h2, "R3");
    step(8'hFF, 8'hFF, 8'h59, 4'h0, 4'h2, "R3");
    step(8'hFF, 8'hFF, 8'h59, 4'h2, 4'h0, "R6");
    // R7 event together with acknowledge
    step(8'hF7, 8'hFF, 8'h59, 4'h0, 4'h2, "R3");
    step(8'hFF, 8'hFF, 8'h59, 4'h0, 4'h2, "R3");
    step(8'hF7, 8'hFF, 8'h59, 4'h2, 4'h2, "R7");
    step(8'hFF, 8'hFF, 8'h59, 4'h0, 4'h2, "R7");
    step(8'hFF, 8'hFF, 8'h59, 4'h2, 4'h0, "R6");
    // R8 sensitivity rewrite clears, then R4 both edges
    step(8'hF7, 8'hFF, 8'h59, 4'h0, 4'h2, "R3");
    step(8'hF7, 8'hFF, 8'h5D, 4'h0, 4'h0, "R8");
    step(8'hFF, 8'hFF, 8'h5D, 4'h0, 4'h2, "R4");
    step(8'hFF, 8'hFF, 8'h5D, 4'h2, 4'h0, "R6");
    step(8'hF7, 8'hFF, 8'h5D, 4'h0, 4'h2, "R4");
    step(8'hF7, 8'hFF, 8'h5D, 4'h2, 4'h0, "R6");
    // R8 clear wins over a simultaneous qualifying edge
    step(8'hFF, 8'hFF, 8'h55, 4'h0, 4'h0, "R8");
    step(8'hFF, 8'hFF, 8'h55, 4'h0, 4'h0, "R8");
    // R5 level mode on vector 2
    step(8'hFF, 8'hFF, 8'h45, 4'h0, 4'h0, "R8");
    step(8'hEF, 8'hFF, 8'h45, 4'h0, 4'h4, "R5");
    step(8'hEF, 8'hFF, 8'h45, 4'h4, 4'h4, "R5");
    step(8'hEF, 8'hFF, 8'h45, 4'h0, 4'h4, "R5");
    step(8'hFF, 8'hFF, 8'h45, 4'h0, 4'h4, "R5");
    step(8'hFF, 8'hFF, 8'h45, 4'h4, 4'h0, "R6");
    // R11 independent vectors
    step(8'hBF, 8'hFF, 8'h45, 4'h0, 4'h0, "R11");
    step(8'hBE, 8'hFF, 8'h45, 4'h0, 4'h0, "R11");
    step(8'hFF, 8'hFF, 8'h45, 4'h0, 4'h9, "R11");
    step(8'hFF, 8'hFF, 8'h45, 4'h8, 4'h1, "R11");
    step(8'hFF, 8'hFF, 8'h45, 4'h1, 4'h0, "R11");
    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule